// File: doc/BRIEF.md
# Triggered Event Data Streamer

This block stands in for a digitizer front end during link bring-up. Every trigger pulse queues one event of fixed length. Each event is a series of 32-bit words, and the block streams those words to a downstream reader over a parallel link. Each word carries its own event number and its position inside the event, so a receiver can detect reordering or loss without knowing anything else about the source.

The link uses three handshake signals:
- The block raises `link_req` while any queued event is not yet fully sent.
- The reader drives `link_en` to say it will accept data.
- The block marks each word on the bus with `link_vld`.

When the reader withdraws enable, valid keeps running for two more cycles, and the words sent in that tail count as delivered. If an event is cut off part way, the block keeps request high with valid low. When enable returns, it resumes that event at the next unsent word, ahead of any event queued later. When triggers arrive faster than events drain, request never drops, and the reader may use any block size it likes.

Top module: `evt_streamer`

## Requirements
- R1: A synchronous active-high reset clears the queue, the word index and the event number, and drives `link_req` and `link_vld` low. The first word after reset carries event 0, index 0.
- R2: Bits 31:16 of `link_data` hold the event number, which is the count of completed events modulo 65536. Bits 15:0 hold the word index, which counts up from 0 to EVENT_WORDS-1 (default 1536) within each event.
- R3: Each accepted trigger yields exactly EVENT_WORDS words with `link_vld` high. The index advances only on cycles where `link_vld` is high.
- R4: `link_req` is high exactly while an accepted event is not fully sent. It falls in the cycle after the last word if nothing else is queued.
- R5: A trigger that arrives while an event is being sent keeps `link_req` high without a gap. With enable held, word 0 of the next event follows the last word of the current one in the very next cycle.
- R6: `link_vld` rises one cycle after `link_en` is first sampled high while data is pending. After `link_en` is sampled low, `link_vld` stays high for exactly two more cycles and then goes low.
- R7: While enable is withdrawn mid-event, `link_req` stays high and `link_vld` stays low. On re-enable, the unsent remainder of that event is sent before any newer event.
- R8: Up to 2^PEND_W-1 events (15 by default) can be pending. A trigger that arrives when the queue is full is ignored.
- R9: When a trigger coincides with the clock edge that delivers the last word of an event, the trigger is kept. This holds even when the queue is full, and the next event starts at once.
- R10: `link_vld` is never high while `link_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Trigger; one event is queued per cycle it is high |
| link_en | input | 1 | Reader accepts data |
| link_req | output | 1 | Data pending |
| link_vld | output | 1 | Word on `link_data` is delivered at the next edge |
| link_data | output | 32 | Event number (31:16) and word index (15:0) |

## Verification
The two functions that can share a cycle are trigger acceptance and event completion. Both act on the pending count in the same edge. The bench provokes this by waiting for the last index of an event to appear on the bus and raising the trigger for exactly that edge. It then checks that request stays high and that word 0 of a new event appears in the next cycle. The scoreboard then confirms that exactly one extra event drains before request falls.

// File: rtl/evt_streamer.sv
module evt_streamer #(
  parameter int EVENT_WORDS = 1536,
  parameter int PEND_W      = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        trig,
  input  logic        link_en,
  output logic        link_req,
  output logic        link_vld,
  output logic [31:0] link_data
);
  localparam logic [15:0]       LAST_IDX = 16'(EVENT_WORDS - 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] pend, pend_nx;
  logic [15:0]       widx, evno;
  logic [1:0]        en_hist;
  logic              vld;

  wire done = vld && (widx == LAST_IDX);
  wire take = trig && ((pend != PEND_MAX) || done);

  always_comb begin
    case ({take, done})
      2'b10:   pend_nx = pend + 1'b1;
      2'b01:   pend_nx = pend - 1'b1;
      default: pend_nx = pend;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      widx    <= '0;
      evno    <= '0;
      en_hist <= '0;
      vld     <= 1'b0;
    end else begin
      pend    <= pend_nx;
      en_hist <= {en_hist[0], link_en};
      vld     <= (pend_nx != '0) && (link_en || (|en_hist));
      if (vld) begin
        if (done) begin
          widx <= '0;
          evno <= evno + 16'd1;
        end else begin
          widx <= widx + 16'd1;
        end
      end
    end
  end

  assign link_req  = (pend != '0);
  assign link_vld  = vld;
  assign link_data = {evno, widx};

  AST_VLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) link_vld |-> link_req); // R10
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst) !link_vld |=> $stable(link_data)); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (link_vld && link_data[15:0] != LAST_IDX) |=> link_data[15:0] == $past(link_data[15:0]) + 16'd1); // R2
  AST_EVNO_STEP: assert property (@(posedge clk) disable iff (rst)
    (link_vld && link_data[15:0] == LAST_IDX) |=> (link_data == {$past(link_data[31:16]) + 16'd1, 16'd0})); // R2
  AST_REQ_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(link_req) |-> ($past(link_vld) && $past(link_data[15:0]) == LAST_IDX)); // R4
endmodule

// File: tb/evt_streamer_tb.sv
module evt_streamer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 1536;
  localparam int QMAX       = 15;

  logic clk = 1'b0, rst = 1'b1, trig = 1'b0, link_en = 1'b0;
  logic link_req, link_vld;
  logic [31:0] link_data;

  int checks = 0, errors = 0;
  int queued = 0;
  logic [15:0] next_ev = 16'd0;
  logic [31:0] exp_q[$];
  logic watch_req = 1'b0, req_gap = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_streamer u_dut (.clk(clk), .rst(rst), .trig(trig), .link_en(link_en),
                      .link_req(link_req), .link_vld(link_vld), .link_data(link_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_event();
    for (int i = 0; i < WORDS; i++) exp_q.push_back({next_ev, 16'(i)});
    next_ev = next_ev + 16'd1;
    queued++;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (watch_req && !link_req) req_gap = 1'b1;
      if (link_vld) begin
        check("R10 vld implies req", {31'd0, link_req}, 32'd1);
        if (exp_q.size() == 0) check("R3 unexpected word", link_data, 32'hxxxxxxxx);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check("R2 word order", link_data, e);
          if (e[15:0] == 16'(WORDS - 1)) queued--;
        end
      end
    end
  end

  task automatic wait_idle();
    while (link_vld || link_req) @(negedge clk);
  endtask

  task automatic trig_pulse();
    trig = 1'b1;
    if (queued < QMAX) push_event();
    @(negedge clk);
    trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 req after reset", {31'd0, link_req}, 32'd0);
    check("R1 vld after reset", {31'd0, link_vld}, 32'd0);

    // enable with nothing queued
    link_en = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 no data without trigger", {30'd0, link_req, link_vld}, 32'd0);

    // single event
    @(negedge clk);
    trig_pulse();
    check("R6 vld rises", {31'd0, link_vld}, 32'd1);
    check("R1 first word", link_data, 32'h0000_0000);
    wait_idle();
    check("R4 req drops after event", {31'd0, link_req}, 32'd0);
    @(posedge clk);
    check("R3 event length", exp_q.size(), 32'd0);

    // back-to-back events
    @(negedge clk);
    trig_pulse();
    watch_req = 1'b1;
    repeat (100) @(negedge clk);
    trig_pulse();
    repeat (2 * WORDS - 110) @(negedge clk);
    watch_req = 1'b0;
    check("R5 no req gap", {31'd0, req_gap}, 32'd0);
    wait_idle();
    @(posedge clk);
    check("R5 both events sent", exp_q.size(), 32'd0);

    // interruption and resume
    @(negedge clk);
    trig_pulse();
    repeat (500) @(negedge clk);
    link_en = 1'b0;
    @(negedge clk);
    check("R6 lag cycle 1", {31'd0, link_vld}, 32'd1);
    @(negedge clk);
    check("R6 lag cycle 2", {31'd0, link_vld}, 32'd1);
    @(negedge clk);
    check("R6 vld dropped", {31'd0, link_vld}, 32'd0);
    trig_pulse();
    repeat (20) @(negedge clk);
    check("R7 paused req held, vld low", {30'd0, link_req, link_vld}, 32'd2);
    link_en = 1'b1;
    @(negedge clk);
    check("R7 resume index", {15'd0, link_vld, link_data[15:0]}, {15'd0, 1'b1, 16'd503});
    wait_idle();
    @(posedge clk);
    check("R7 remainder then new event", exp_q.size(), 32'd0);

    // saturation
    @(negedge clk);
    link_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 20; k++) trig_pulse();
    check("R8 req while queued", {31'd0, link_req}, 32'd1);
    link_en = 1'b1;
    wait_idle();
    @(posedge clk);
    check("R8 only 15 events", exp_q.size(), 32'd0);
    check("R8 queue drained", 32'(queued), 32'd0);

    // trigger coinciding with completion
    @(negedge clk);
    trig_pulse();
    while (!(link_vld && link_data[15:0] == 16'(WORDS - 1))) @(negedge clk);
    trig_pulse();
    check("R9 req kept", {31'd0, link_req}, 32'd1);
    check("R9 next event starts", {15'd0, link_vld, link_data[15:0]}, {15'd0, 1'b1, 16'd0});
    wait_idle();
    @(posedge clk);
    check("R9 exactly one more event", exp_q.size(), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule